// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Clock Output

This block turns a parallel word into an LSB-first serial frame: one low start bit, eight or nine data bits, then a high stop period of one, half, two or one-and-a-half bit times. Each bit lasts sixteen baud ticks, and a half stop bit lasts eight. A companion clock pin can run alongside the data so that a synchronous receiver can capture each data bit. The clock pin only pulses during the data bits. It never pulses during the start bit, during the stop period or while the block is idle. Three settings shape the clock pin: its idle level, which of the two transitions in a bit is the capture edge, and whether the most significant data bit gets a pulse.

The word enters through a valid/ready handshake. `tx_ready` is high only when the block is enabled and idle. A word is taken on a clock edge where both `tx_valid` and `tx_ready` are high. The configuration is captured into an internal register by `cfg_we`. The write is ignored while the block is enabled or still sending.

The controller has four states. IDLE goes to START when a word is accepted. START goes to DATA after 16 ticks. DATA loops once per bit and goes to STOP after the last data bit. STOP goes back to IDLE when the selected stop length has elapsed. Ticks that arrive in IDLE are ignored.

Top module: `sync_ser_tx`

## Requirements
- R1: When idle, `txd` is high. A frame drives `txd` low for 16 ticks, then sends the data bits LSB first for 16 ticks each, then drives it high for the stop period.
- R2: When `cfg_wlen9`=0 a frame carries data bits 7:0. When `cfg_wlen9`=1 it carries bits 8:0.
- R3: The stop field `cfg_stop` selects the stop period: 00 gives 16 ticks, 01 gives 8 ticks, 10 gives 32 ticks and 11 gives 24 ticks.
- R4: When `cfg_ck_en`=0, `sck` stays at the idle level for the whole frame and emits no transitions.
- R5: Outside the data bits, `sck` equals `cfg_cpol`: 0 is a low idle level and 1 is a high idle level.
- R6: With `cfg_cpha`=0, `sck` leaves its idle level 8 ticks into each data bit and returns at the end of the bit. The data changes half a bit before that first transition. With `cfg_cpha`=1, `sck` leaves its idle level at the start of the bit, together with the data change, and returns 8 ticks later.
- R7: When `cfg_last`=0, the most significant data bit gets no clock pulse. When `cfg_last`=1, it gets one. With the clock enabled, a frame therefore shows 2·(n−1) or 2·n transitions, where n is the number of data bits.
- R8: `sck` does not pulse during the start bit or during the stop period.
- R9: A `cfg_we` write is ignored while `en` is high or a frame is in progress. The new settings take effect only from a write made while the block is disabled and idle.
- R10: `tx_ready` is high exactly when `en` is high and no frame is in progress. `busy` rises on the edge that accepts a word and falls on the edge that ends the last stop tick.
- R11: After reset, `txd`=1, `sck`=0, `busy`=0, and the configuration is 8 data bits, one stop bit, clock disabled, with polarity, phase and last-bit pulse all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; locks the configuration while high |
| baud_tick | input | 1 | One-cycle pulse per baud sub-interval (16 per bit) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wlen9 | input | 1 | 1 = nine data bits, 0 = eight |
| cfg_stop | input | 2 | Stop period select |
| cfg_ck_en | input | 1 | Clock pin output enable |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Capture on second (1) or first (0) transition |
| cfg_last | input | 1 | Emit the pulse for the most significant data bit |
| tx_data | input | DATA_W | Word to send |
| tx_valid | input | 1 | Word valid |
| tx_ready | output | 1 | Block can take a word |
| txd | output | 1 | Serial data line |
| sck | output | 1 | Clock pin |
| busy | output | 1 | Frame in progress |

## Verification
The embedded assertions check the following on every cycle:
- the configuration is frozen while the lock is active;
- `tx_ready` never coincides with `busy`;
- a frame opens with a low start bit and closes high;
- `sck` sits at its idle level during the start and stop states and whenever the clock is disabled.

Only the bench's scenarios can show the following, because they depend on tick counts across a whole frame:
- the exact tick placement of each clock transition for both phases;
- the LSB-first bit order;
- the four stop lengths;
- the presence or absence of the last pulse;
- that a locked write really had no effect on the next frame.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE  = 2'b00,
        STOP_HALF = 2'b01,
        STOP_TWO  = 2'b10,
        STOP_ONEH = 2'b11
    } stop_sel_e;

    typedef struct packed {
        logic      wlen9;
        stop_sel_e stop;
        logic      ck_en;
        logic      cpol;
        logic      cpha;
        logic      last;
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '{
        wlen9: 1'b0,
        stop:  STOP_ONE,
        ck_en: 1'b0,
        cpol:  1'b0,
        cpha:  1'b0,
        last:  1'b0
    };

endpackage

// File: rtl/sstx_cfg.sv
module sstx_cfg
    import sstx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    we,
    input  logic    lock,
    input  tx_cfg_t cfg_in,
    output tx_cfg_t cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (we && !lock) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/sstx_fsm.sv
module sstx_fsm
    import sstx_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int BIT_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  tx_cfg_t           cfg,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              busy,
    output tx_state_e         state,
    output logic [$clog2(2*BIT_TICKS)-1:0] cnt,
    output logic              last_bit,
    output logic              txd
);

    localparam int CNT_W = $clog2(2*BIT_TICKS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] END_BIT  = CNT_W'(BIT_TICKS - 1);
    localparam logic [CNT_W-1:0] END_HALF = CNT_W'(BIT_TICKS/2 - 1);
    localparam logic [CNT_W-1:0] END_TWO  = CNT_W'(2*BIT_TICKS - 1);
    localparam logic [CNT_W-1:0] END_ONEH = CNT_W'(BIT_TICKS + BIT_TICKS/2 - 1);
    localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

    tx_state_e         state_nx;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  idx_top;
    logic [CNT_W-1:0]  stop_end;
    logic [DATA_W-1:0] shreg;
    logic              accept;
    logic              bit_done;
    logic              stop_done;

    assign ready     = en && (state == ST_IDLE);
    assign accept    = ready && valid;
    assign idx_top   = cfg.wlen9 ? IDX_LONG : IDX_SHORT;
    assign last_bit  = (bit_idx == idx_top);
    assign bit_done  = tick && (cnt == END_BIT);
    assign stop_done = tick && (cnt == stop_end);

    always_comb begin
        unique case (cfg.stop)
            STOP_ONE:  stop_end = END_BIT;
            STOP_HALF: stop_end = END_HALF;
            STOP_TWO:  stop_end = END_TWO;
            STOP_ONEH: stop_end = END_ONEH;
            default:   stop_end = END_BIT;
        endcase
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept)               state_nx = ST_START;
            ST_START: if (bit_done)             state_nx = ST_DATA;
            ST_DATA:  if (bit_done && last_bit) state_nx = ST_STOP;
            ST_STOP:  if (stop_done)            state_nx = ST_IDLE;
            default:                            state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // tick counter, bit index and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    if (accept) shreg <= data;
                end
                ST_START: begin
                    if (bit_done)  cnt <= '0;
                    else if (tick) cnt <= cnt + 1'b1;
                end
                ST_DATA: begin
                    if (bit_done) begin
                        cnt     <= '0;
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {1'b0, shreg[DATA_W-1:1]};
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (stop_done) cnt <= '0;
                    else if (tick) cnt <= cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:  txd = 1'b1;
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA || state == ST_START) |-> (cnt <= END_BIT)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R10

endmodule

// File: rtl/sstx_sckgen.sv
module sstx_sckgen
    import sstx_pkg::*;
#(
    parameter int BIT_TICKS = 16
) (
    input  tx_state_e                      state,
    input  logic [$clog2(2*BIT_TICKS)-1:0] cnt,
    input  logic                           last_bit,
    input  tx_cfg_t                        cfg,
    output logic                           sck
);

    localparam int CNT_W = $clog2(2*BIT_TICKS);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BIT_TICKS/2);

    logic second_half;
    logic active;
    logic pulse_ok;

    always_comb begin
        second_half = (cnt >= HALF);
        active      = cfg.cpha ? !second_half : second_half;
        pulse_ok    = cfg.ck_en && (state == ST_DATA) && (!last_bit || cfg.last);
        sck         = cfg.cpol ^ (pulse_ok && active);
    end

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sstx_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int BIT_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              baud_tick,
    input  logic              cfg_we,
    input  logic              cfg_wlen9,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_ck_en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_last,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              sck,
    output logic              busy
);

    localparam int CNT_W = $clog2(2*BIT_TICKS);

    tx_cfg_t    cfg_in;
    tx_cfg_t    cfg;
    tx_state_e  state;
    logic [CNT_W-1:0] cnt;
    logic       last_bit;

    always_comb begin
        cfg_in.wlen9 = cfg_wlen9;
        cfg_in.stop  = stop_sel_e'(cfg_stop);
        cfg_in.ck_en = cfg_ck_en;
        cfg_in.cpol  = cfg_cpol;
        cfg_in.cpha  = cfg_cpha;
        cfg_in.last  = cfg_last;
    end

    sstx_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .lock   (en | busy),
        .cfg_in (cfg_in),
        .cfg_q  (cfg)
    );

    sstx_fsm #(.DATA_W(DATA_W), .BIT_TICKS(BIT_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (baud_tick),
        .cfg      (cfg),
        .data     (tx_data),
        .valid    (tx_valid),
        .ready    (tx_ready),
        .busy     (busy),
        .state    (state),
        .cnt      (cnt),
        .last_bit (last_bit),
        .txd      (txd)
    );

    sstx_sckgen #(.BIT_TICKS(BIT_TICKS)) u_sck (
        .state    (state),
        .cnt      (cnt),
        .last_bit (last_bit),
        .cfg      (cfg),
        .sck      (sck)
    );

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !busy); // R10
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R1
    AST_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(txd) && txd)); // R1
    AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START || state == ST_STOP || state == ST_IDLE) |-> (sck == cfg.cpol)); // R8
    AST_SCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.ck_en |-> (sck == cfg.cpol)); // R4

endmodule

// File: tb/sim_sync_ser_tx.sv
`timescale 1ns/1ps
module sim_sync_ser_tx;

    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, baud_tick = 1'b0, cfg_we = 1'b0;
    logic cfg_wlen9 = 1'b0, cfg_ck_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_last = 1'b0;
    logic [1:0] cfg_stop = 2'b00;
    logic [DW-1:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, txd, sck, busy;

    int errors = 0, checks = 0, cycles = 0, tick_div = 1;

    // reference model state
    int m_wlen9 = 0, m_stop = 0, m_cken = 0, m_cpol = 0, m_cpha = 0, m_last = 0;
    int m_busy = 0, m_t = 0, m_tot = 0, m_nb = 8;
    logic [DW-1:0] m_data = '0;
    int edges = 0, ticks_busy = 0;
    logic prev_sck = 1'b0;

    always #5 clk = ~clk;

    sync_ser_tx #(.DATA_W(DW), .BIT_TICKS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .baud_tick(baud_tick), .cfg_we(cfg_we),
        .cfg_wlen9(cfg_wlen9), .cfg_stop(cfg_stop), .cfg_ck_en(cfg_ck_en),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_last(cfg_last),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .txd(txd), .sck(sck), .busy(busy)
    );

    function automatic int stop_len(int s);
        case (s)
            0: return 16;
            1: return 8;
            2: return 32;
            default: return 24;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
        end
    endtask

    // tick generator
    always @(negedge clk) begin
        cycles++;
        baud_tick = ((cycles % tick_div) == 0);
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wlen9 = 0; m_stop = 0; m_cken = 0; m_cpol = 0; m_cpha = 0; m_last = 0;
            m_busy = 0; m_t = 0;
        end else if (m_busy == 0) begin
            if (cfg_we && !en) begin
                m_wlen9 = cfg_wlen9; m_stop = cfg_stop; m_cken = cfg_ck_en;
                m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_last = cfg_last;
            end
            if (en && tx_valid) begin
                m_busy = 1; m_t = 0; m_data = tx_data;
                m_nb = m_wlen9 ? 9 : 8;
                m_tot = 16 * (1 + m_nb) + stop_len(m_stop);
            end
        end else if (baud_tick) begin
            m_t++;
            if (m_t == m_tot) m_busy = 0;
        end
    end

    // per-cycle comparison, away from the edge
    always @(negedge clk) begin
        int e_txd, e_sck, bi, ph;
        #1;
        if (rst_n) begin
            e_txd = 1;
            e_sck = m_cpol;
            if (m_busy != 0) begin
                if (m_t < 16) e_txd = 0;
                else if (m_t < 16 + 16*m_nb) begin
                    bi = (m_t - 16) / 16;
                    ph = (m_t - 16) % 16;
                    e_txd = m_data[bi];
                    if (m_cken != 0 && (bi != m_nb-1 || m_last != 0))
                        e_sck = m_cpol ^ ((m_cpha != 0) ? (ph < 8) : (ph >= 8));
                end
            end
            check("R1/R2 txd", txd, e_txd);
            check("R5/R6/R8 sck", sck, e_sck);
            check("R10 busy", busy, m_busy);
            check("R10 tx_ready", tx_ready, (en && m_busy == 0) ? 1 : 0);
            if (busy && baud_tick) ticks_busy++;
            if (busy && sck != prev_sck) edges++;
            prev_sck = sck;
        end
    end

    task automatic configure(input int w9, input int st, input int ck, input int pol, input int pha, input int lst);
        @(negedge clk);
        en = 1'b0;
        cfg_we = 1'b1; cfg_wlen9 = w9[0]; cfg_stop = st[1:0]; cfg_ck_en = ck[0];
        cfg_cpol = pol[0]; cfg_cpha = pha[0]; cfg_last = lst[0];
        @(negedge clk);
        cfg_we = 1'b0;
        en = 1'b1;
    endtask

    task automatic send(input logic [DW-1:0] d, input int exp_ticks, input int exp_edges);
        @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        ticks_busy = 0; edges = 0;
        @(negedge clk);
        tx_valid = 1'b0;
        while (m_busy != 0) @(negedge clk);
        @(negedge clk);
        check("R3 frame ticks", ticks_busy, exp_ticks);
        check("R4/R7 sck edges", edges, exp_edges);
    endtask

    initial begin
        #2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R11 txd reset", txd, 1);
        check("R11 sck reset", sck, 0);
        check("R11 busy reset", busy, 0);
        check("R11 ready while disabled", tx_ready, 0);

        // defaults: 8 bits, 1 stop, clock off (R4, R11)
        en = 1'b1;
        send(9'h0A5, 16*9 + 16, 0);

        // R6 phase 0, R7 no last pulse, R3 two stop bits, slower ticks
        tick_div = 2;
        configure(0, 2, 1, 0, 0, 0);
        send(9'h03C, 16*9 + 32, 14);

        // R5 high idle, R6 phase 1, R7 last pulse, R2 nine bits, R3 1.5 stop
        tick_div = 1;
        configure(1, 3, 1, 1, 1, 1);
        send(9'h1A5, 16*10 + 24, 18);

        // R6 phase 0 with last pulse, R3 half stop
        tick_div = 3;
        configure(0, 1, 1, 0, 0, 1);
        send(9'h0C3, 16*9 + 8, 16);

        // R9 write during a frame and while enabled is ignored
        tick_div = 1;
        @(negedge clk);
        tx_data = 9'h155; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        cfg_we = 1'b1; cfg_stop = 2'b10; cfg_ck_en = 1'b0; cfg_wlen9 = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        while (m_busy != 0) @(negedge clk);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        send(9'h0F0, 16*9 + 8, 16);  // R9 settings still from before

        // R10 valid while disabled is not taken
        @(negedge clk);
        en = 1'b0; tx_valid = 1'b1;
        repeat (4) @(negedge clk);
        #2;
        check("R10 no accept while disabled", busy, 0);
        tx_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog R10: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule